// File: doc/BRIEF.md
# Command Word Decoder with Interface Lock

This block sits behind a serial-interface frame assembler. Each frame yields one 16-bit command word. The block classifies that word and issues the matching action as a single-cycle strobe. The actions are chip reset, standby and wakeup, a register read and a register write. For a read or a write, the block also extracts the target register address and the number of registers to transfer.

The block holds one piece of state, the interface lock. A dedicated word sets it and another clears it. While the lock is set, only harmless traffic takes effect: the no-op, register reads, the unlock word, and the reporting of unrecognised words. Every other word is dropped without a strobe.

A word that matches no known pattern raises an illegal-command pulse and changes nothing else. All outputs are registered. The result of a word presented with `word_vld` high at one rising edge is visible right after that edge.

Top module: `cmd_word_decoder`

## Requirements
- R1: After reset the lock bit reads 0 (unlocked), every strobe is low, and `reg_addr`/`reg_num` read 0.
- R2: While unlocked, the word 0x0011 gives a one-cycle `rst_stb`, the word 0x0022 a one-cycle `sby_stb` and the word 0x0033 a one-cycle `wak_stb`.
- R3: The word 0x0555 sets `locked` to 1 and the word 0x0666 clears it to 0. The new value is visible after the edge that takes the word.
- R4: A word with bits [15:13] = 101 is a read, accepted locked or not. It pulses `rd_stb`, loads `reg_addr` from bits [12:7] and loads `reg_num` with bits [6:0] plus one, which spans 1 to 128.
- R5: A word with bits [15:13] = 011 is a write. While unlocked it pulses `wr_stb` and loads `reg_addr` and `reg_num` the same way as a read.
- R6: While locked, a write, 0x0011, 0x0022, 0x0033 or 0x0555 gives no strobe and leaves `reg_addr`, `reg_num` and `locked` unchanged.
- R7: The word 0x0000 gives no strobe and changes no output, locked or not.
- R8: Any word that matches none of the patterns above, locked or not, gives a one-cycle `bad_stb` and changes neither `locked`, `reg_addr` nor `reg_num`.
- R9: A cycle with `word_vld` low gives no strobe and changes no output state.
- R10: At most one strobe is high in any cycle. Back-to-back valid words are each decoded in their own cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_vld | input | 1 | Command word valid for this cycle |
| word_in | input | 16 | Command word |
| rst_stb | output | 1 | Reset request pulse |
| sby_stb | output | 1 | Standby request pulse |
| wak_stb | output | 1 | Wakeup request pulse |
| rd_stb | output | 1 | Register read request pulse |
| wr_stb | output | 1 | Register write request pulse |
| bad_stb | output | 1 | Illegal command pulse |
| reg_addr | output | 6 | Start register address of the last accepted read or write |
| reg_num | output | 8 | Register count of the last accepted read or write |
| locked | output | 1 | Interface lock status, 1 = locked |

## Verification
The assertions check several properties on every cycle. At most one strobe is high at a time. No strobe or lock change follows an idle cycle. A locked interface never emits a write, reset, standby or wakeup strobe. An illegal pulse never comes with a change of lock or address state. The lock only rises after the lock word and only falls after the unlock word. A read or write count is never zero.

Other behaviour needs the bench's scenarios and its per-cycle reference model. That covers the exact field extraction at the address and count extremes and the full set of unrecognised encodings. It also covers dropping each gated command while locked and recovery after unlock, back-to-back words, and a reset arriving mid-traffic.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;

  typedef enum logic [3:0] {
    K_NOP = 4'd0,
    K_RST = 4'd1,
    K_SBY = 4'd2,
    K_WAK = 4'd3,
    K_LCK = 4'd4,
    K_ULK = 4'd5,
    K_RD  = 4'd6,
    K_WR  = 4'd7,
    K_BAD = 4'd8
  } cmd_kind_e;

  // Fixed command encodings (16-bit words)
  localparam logic [15:0] W_NOP = 16'h0000;
  localparam logic [15:0] W_RST = 16'h0011;
  localparam logic [15:0] W_SBY = 16'h0022;
  localparam logic [15:0] W_WAK = 16'h0033;
  localparam logic [15:0] W_LCK = 16'h0555;
  localparam logic [15:0] W_ULK = 16'h0666;

  // Leading tags of the register access commands
  localparam logic [2:0] TAG_RD = 3'b101;
  localparam logic [2:0] TAG_WR = 3'b011;

  localparam int TAG_W = 3;

endpackage

// File: rtl/cmd_classify.sv
module cmd_classify
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 7,
  localparam int WORD_W = TAG_W + ADDR_W + CNT_W
) (
  input  logic [WORD_W-1:0] word,
  output cmd_kind_e         kind,
  output logic [ADDR_W-1:0] addr,
  output logic [CNT_W-1:0]  cnt
);

  logic [TAG_W-1:0] tag;

  assign tag  = word[WORD_W-1 -: TAG_W];
  assign addr = word[CNT_W +: ADDR_W];
  assign cnt  = word[CNT_W-1:0];

  always_comb begin
    if (tag == TAG_RD)                   kind = K_RD;
    else if (tag == TAG_WR)              kind = K_WR;
    else if (word == WORD_W'(W_NOP))     kind = K_NOP;
    else if (word == WORD_W'(W_RST))     kind = K_RST;
    else if (word == WORD_W'(W_SBY))     kind = K_SBY;
    else if (word == WORD_W'(W_WAK))     kind = K_WAK;
    else if (word == WORD_W'(W_LCK))     kind = K_LCK;
    else if (word == WORD_W'(W_ULK))     kind = K_ULK;
    else                                 kind = K_BAD;
  end

endmodule

// File: rtl/cmd_lock_gate.sv
module cmd_lock_gate
  import cmd_dec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      vld,
  input  cmd_kind_e kind,
  output logic      take,
  output logic      locked
);

  logic lock_d;
  logic lock_en;
  logic allowed;

  // While locked only harmless kinds pass
  always_comb begin
    allowed = !locked || (kind == K_NOP) || (kind == K_RD) ||
              (kind == K_ULK) || (kind == K_BAD);
    take    = vld && allowed;
  end

  always_comb begin
    lock_en = 1'b0;
    lock_d  = locked;
    if (take && (kind == K_LCK)) begin
      lock_en = 1'b1;
      lock_d  = 1'b1;
    end else if (take && (kind == K_ULK)) begin
      lock_en = 1'b1;
      lock_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       locked <= 1'b0;
    else if (lock_en) locked <= lock_d;
  end

endmodule

// File: rtl/cmd_strobe_reg.sv
module cmd_strobe_reg
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 7,
  localparam int NUM_W = CNT_W + 1,
  localparam int N_STB = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  cmd_kind_e         kind,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  cnt,
  output logic [N_STB-1:0]  stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [NUM_W-1:0]  reg_num
);

  // Strobe order: rst, sby, wak, rd, wr, bad
  localparam cmd_kind_e STB_KIND [N_STB] = '{K_RST, K_SBY, K_WAK, K_RD, K_WR, K_BAD};

  logic [N_STB-1:0]  stb_d;
  logic              xfer_en;
  logic [ADDR_W-1:0] addr_d;
  logic [NUM_W-1:0]  num_d;

  for (genvar i = 0; i < N_STB; i++) begin : g_stb
    assign stb_d[i] = take && (kind == STB_KIND[i]);
  end

  always_comb begin
    xfer_en = take && ((kind == K_RD) || (kind == K_WR));
    addr_d  = addr;
    num_d   = NUM_W'(cnt) + NUM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb <= '0;
    else        stb <= stb_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_addr <= '0;
      reg_num  <= '0;
    end else if (xfer_en) begin
      reg_addr <= addr_d;
      reg_num  <= num_d;
    end
  end

endmodule

// File: rtl/cmd_word_decoder.sv
module cmd_word_decoder
  import cmd_dec_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 7,
  localparam int WORD_W = TAG_W + ADDR_W + CNT_W,
  localparam int NUM_W  = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  output logic              rst_stb,
  output logic              sby_stb,
  output logic              wak_stb,
  output logic              rd_stb,
  output logic              wr_stb,
  output logic              bad_stb,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [NUM_W-1:0]  reg_num,
  output logic              locked
);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  cmd_kind_e         kind;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  cnt;
  logic              take;
  logic [5:0]        stb;

  // Assert asynchronously, release on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  cmd_classify #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cls (
    .word (word_in),
    .kind (kind),
    .addr (addr),
    .cnt  (cnt)
  );

  cmd_lock_gate u_lock (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .vld    (word_vld),
    .kind   (kind),
    .take   (take),
    .locked (locked)
  );

  cmd_strobe_reg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_stb (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .take     (take),
    .kind     (kind),
    .addr     (addr),
    .cnt      (cnt),
    .stb      (stb),
    .reg_addr (reg_addr),
    .reg_num  (reg_num)
  );

  assign rst_stb = stb[0];
  assign sby_stb = stb[1];
  assign wak_stb = stb[2];
  assign rd_stb  = stb[3];
  assign wr_stb  = stb[4];
  assign bad_stb = stb[5];

endmodule

// File: rtl/cmd_word_decoder_chk.sv
module cmd_word_decoder_chk #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 7,
  localparam int WORD_W = 3 + ADDR_W + CNT_W,
  localparam int NUM_W  = CNT_W + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              word_vld,
  input logic [WORD_W-1:0] word_in,
  input logic              rst_stb,
  input logic              sby_stb,
  input logic              wak_stb,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic              bad_stb,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [NUM_W-1:0]  reg_num,
  input logic              locked
);

  logic any_stb;
  assign any_stb = rst_stb | sby_stb | wak_stb | rd_stb | wr_stb | bad_stb;

  assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_stb, sby_stb, wak_stb, rd_stb, wr_stb, bad_stb}));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld |=> !any_stb && $stable(locked) && $stable(reg_addr) && $stable(reg_num));

  assert_locked_gates_R6: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> !(wr_stb || rst_stb || sby_stb || wak_stb));

  assert_bad_no_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_stb |-> $stable(locked) && $stable(reg_addr) && $stable(reg_num));

  assert_lock_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(word_vld) && ($past(word_in) == WORD_W'(16'h0555)));

  assert_lock_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> $past(word_vld) && ($past(word_in) == WORD_W'(16'h0666)));

  assert_count_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb || wr_stb) |-> (reg_num != '0));

endmodule

bind cmd_word_decoder cmd_word_decoder_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .word_vld (word_vld),
  .word_in  (word_in),
  .rst_stb  (rst_stb),
  .sby_stb  (sby_stb),
  .wak_stb  (wak_stb),
  .rd_stb   (rd_stb),
  .wr_stb   (wr_stb),
  .bad_stb  (bad_stb),
  .reg_addr (reg_addr),
  .reg_num  (reg_num),
  .locked   (locked)
);

// File: tb/sim_cmd_word_decoder.sv
`timescale 1ns/1ps
module sim_cmd_word_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_vld = 1'b0;
  logic [15:0] word_in = 16'h0000;
  logic        rst_stb, sby_stb, wak_stb, rd_stb, wr_stb, bad_stb;
  logic [5:0]  reg_addr;
  logic [7:0]  reg_num;
  logic        locked;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cmd_word_decoder u0 (
    .clk(clk), .rst_n(rst_n), .word_vld(word_vld), .word_in(word_in),
    .rst_stb(rst_stb), .sby_stb(sby_stb), .wak_stb(wak_stb),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .bad_stb(bad_stb),
    .reg_addr(reg_addr), .reg_num(reg_num), .locked(locked)
  );

  // ---------------- behavioural reference model ----------------
  bit m_lock, m_rst, m_sby, m_wak, m_rd, m_wr, m_bad;
  int m_addr, m_num;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lock = 0; m_rst = 0; m_sby = 0; m_wak = 0; m_rd = 0; m_wr = 0; m_bad = 0;
      m_addr = 0; m_num = 0;
    end else begin
      int w;
      int top;
      w = word_in;
      top = w / 8192;
      m_rst = 0; m_sby = 0; m_wak = 0; m_rd = 0; m_wr = 0; m_bad = 0;
      if (word_vld) begin
        if (top == 5) begin
          m_rd = 1; m_addr = (w / 128) % 64; m_num = (w % 128) + 1;
        end else if (top == 3) begin
          if (!m_lock) begin
            m_wr = 1; m_addr = (w / 128) % 64; m_num = (w % 128) + 1;
          end
        end else if (w == 'h0000) begin
        end else if (w == 'h0011) begin
          if (!m_lock) m_rst = 1;
        end else if (w == 'h0022) begin
          if (!m_lock) m_sby = 1;
        end else if (w == 'h0033) begin
          if (!m_lock) m_wak = 1;
        end else if (w == 'h0555) begin
          m_lock = 1;
        end else if (w == 'h0666) begin
          m_lock = 0;
        end else begin
          m_bad = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R3 locked",  locked,   m_lock);
      chk("R2 rst_stb", rst_stb,  m_rst);
      chk("R2 sby_stb", sby_stb,  m_sby);
      chk("R2 wak_stb", wak_stb,  m_wak);
      chk("R4 rd_stb",  rd_stb,   m_rd);
      chk("R5 wr_stb",  wr_stb,   m_wr);
      chk("R8 bad_stb", bad_stb,  m_bad);
      chk("R4 reg_addr", reg_addr, m_addr);
      chk("R4 reg_num",  reg_num,  m_num);
    end
  end

  // ---------------- stimulus ----------------
  task automatic send(input logic [15:0] w);
    @(negedge clk);
    word_vld = 1'b1;
    word_in  = w;
    @(negedge clk);
    word_vld = 1'b0;
    word_in  = $urandom;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [2:0] tag, input int a, input int c);
    return {tag, 6'(a), 7'(c)};
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    chk("R1 locked", locked, 0);
    chk("R1 strobes", {rst_stb, sby_stb, wak_stb, rd_stb, wr_stb, bad_stb}, 0);
    chk("R1 reg_addr", reg_addr, 0);
    chk("R1 reg_num", reg_num, 0);

    // R2 mode strobes while unlocked
    send(16'h0011); chk("R2 reset strobe", rst_stb, 1);
    idle(1);        chk("R2 one cycle", rst_stb, 0);
    send(16'h0022); chk("R2 standby strobe", sby_stb, 1);
    send(16'h0033); chk("R2 wakeup strobe", wak_stb, 1);

    // R4 reads at field extremes
    send(mk(3'b101, 63, 127)); chk("R4 addr max", reg_addr, 63); chk("R4 num max", reg_num, 128);
    send(mk(3'b101, 0, 0));    chk("R4 addr min", reg_addr, 0);  chk("R4 num min", reg_num, 1);
    // R5 write
    send(mk(3'b011, 21, 5));   chk("R5 wr strobe", wr_stb, 1); chk("R5 addr", reg_addr, 21); chk("R5 num", reg_num, 6);

    // R7 no-op
    send(16'h0000);
    chk("R7 no strobe", {rst_stb, sby_stb, wak_stb, rd_stb, wr_stb, bad_stb}, 0);
    chk("R7 addr kept", reg_addr, 21);

    // R8 illegal words
    send(16'h0012); chk("R8 bad 0012", bad_stb, 1); chk("R8 addr kept", reg_addr, 21);
    send(16'h8000); chk("R8 bad 8000", bad_stb, 1);
    send(16'hFFFF); chk("R8 bad FFFF", bad_stb, 1);
    send(16'h0556); chk("R8 bad 0556", bad_stb, 1); chk("R8 lock kept", locked, 0);

    // R3 lock, then R6 gating
    send(16'h0555); chk("R3 lock set", locked, 1);
    send(mk(3'b011, 9, 9)); chk("R6 write dropped", wr_stb, 0); chk("R6 addr kept", reg_addr, 21);
    send(16'h0011); chk("R6 reset dropped", rst_stb, 0);
    send(16'h0022); chk("R6 standby dropped", sby_stb, 0);
    send(16'h0033); chk("R6 wakeup dropped", wak_stb, 0);
    send(16'h0555); chk("R6 relock stays", locked, 1);
    send(mk(3'b101, 40, 3)); chk("R6 read while locked", rd_stb, 1); chk("R6 read addr", reg_addr, 40);
    send(16'h1234); chk("R8 bad while locked", bad_stb, 1); chk("R8 lock kept locked", locked, 1);
    send(16'h0000); chk("R7 nop locked", locked, 1);
    send(16'h0666); chk("R3 unlock", locked, 0);
    send(mk(3'b011, 2, 64)); chk("R5 write after unlock", wr_stb, 1); chk("R5 num", reg_num, 65);

    // R10 back-to-back words
    @(negedge clk); word_vld = 1'b1; word_in = 16'h0011;
    @(negedge clk); chk("R10 first", rst_stb, 1); word_in = mk(3'b101, 7, 1);
    @(negedge clk); chk("R10 second", rd_stb, 1); chk("R10 one hot", rst_stb, 0); word_in = 16'h0555;
    @(negedge clk); chk("R10 third", locked, 1); word_vld = 1'b0;
    // R9 idle with garbage on the word bus
    word_in = 16'h0666; idle(3); chk("R9 idle keeps lock", locked, 1);
    send(16'h0666);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      logic [15:0] w;
      r = $urandom_range(0, 9);
      case (r)
        0: w = 16'h0011;
        1: w = 16'h0022;
        2: w = 16'h0033;
        3: w = 16'h0555;
        4: w = 16'h0666;
        5: w = mk(3'b101, $urandom, $urandom);
        6: w = mk(3'b011, $urandom, $urandom);
        7: w = 16'h0000;
        default: w = $urandom;
      endcase
      @(negedge clk);
      word_vld = ($urandom_range(0, 3) != 0);
      word_in  = w;
      if (i == 1500) begin
        word_vld = 1'b0;
        rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(3);
        chk("R1 reset mid-run lock", locked, 0);
        chk("R1 reset mid-run addr", reg_addr, 0);
      end
    end
    @(negedge clk); word_vld = 1'b0;
    idle(2);
    done = 1'b1;
    summary();
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end

endmodule